// File: doc/BRIEF.md
# PCI Configuration Space with I/O Window Bases

This block is the 256-byte configuration register file of a single PCI function. It accepts byte-lane writes of one, two or four bytes. Each write lands on consecutive byte offsets, starting at the given offset. Every written byte passes through a per-offset filter. Identification bytes, the interrupt pin and the low status byte are read-only. The command byte accepts only its I/O-enable bit. The standard base-address range cannot be written. The low byte of each I/O base register is masked to its window alignment, with bit 0 forced to one to mark I/O space.

Two I/O base registers are held. One places a 64-byte power management window and the other places a 16-byte SMBus window. The block drives both decoded 16-bit base addresses continuously. When a write changes any of the four bytes of a base register, it raises a one-cycle strobe so that the I/O decoders elsewhere can remap. Reads return one little-endian dword, one cycle after the read address is presented.

Top module: `cfg_space_io`

## Requirements
- R1: After reset the bytes read as follows. Offset 0x06 = 0x80, 0x07 = 0x02, 0x3D = 0x01, 0x40 = 0x01, 0x90 = 0x01, 0x5F = 0x90, 0x63 = 0x60, 0x67 = 0x98. The identification bytes hold their parameter values. Every other byte, including 0x04, 0x05, 0x3C and 0x58 to 0x5B, is 0x00.
- R2: The identification bytes are read-only and keep their parameter values. These are vendor ID at 0x00–0x01, device ID at 0x02–0x03, revision at 0x08, class code at 0x09–0x0B and header type at 0x0E. The interrupt pin byte at 0x3D is also read-only and reads 0x01.
- R3: A write with wr_len of 1, 2 or 4 stores data byte k (bits 8k+7:8k) at offset (wr_addr + k) mod 256, for k below wr_len. Other wr_len values change nothing. Bytes with no special rule store the data unchanged.
- R4: A write whose start offset lies in 0x10 to 0x33 changes nothing. A write that starts below 0x10 and runs into that range still writes its upper bytes.
- R5: At offset 0x04 only bit 0 takes the data lane's bit 0, and bits 7:1 keep their value. Offset 0x06 is read-only. Offsets 0x05 and 0x07 are freely writable.
- R6: The interrupt line byte at 0x3C stores any written value.
- R7: A byte written to 0x40 is stored as (data & 0xC0) | 0x01. Offsets 0x41 to 0x43 store data unchanged.
- R8: A byte written to 0x90 is stored as (data & 0xF0) | 0x01. Offsets 0x91 to 0x93 store data unchanged.
- R9: pm_base equals {byte 0x41, byte 0x40} with bit 0 cleared. sm_base equals {byte 0x91, byte 0x90} with bit 0 cleared. Both reflect a write in the cycle after the write edge.
- R10: pm_changed pulses high for exactly the one cycle after a write in which a byte at 0x40–0x43 got a value different from its old one. sm_changed does the same for 0x90–0x93. A write that stores equal values gives no pulse.
- R11: rd_data returns bytes {A+3, A+2, A+1, A}, where A is rd_addr with bits 1:0 cleared. The value is registered one clock after rd_addr is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | 8 | Start byte offset of the write |
| wr_data | input | 32 | Write data, lane k goes to offset wr_addr+k |
| wr_len | input | 3 | Number of bytes: 1, 2 or 4 |
| rd_addr | input | 8 | Read offset, bits 1:0 ignored |
| rd_data | output | 32 | Registered dword read data |
| pm_base | output | 16 | Power management window base address |
| sm_base | output | 16 | SMBus window base address |
| pm_changed | output | 1 | One-cycle strobe on a PM base change |
| sm_changed | output | 1 | One-cycle strobe on an SMBus base change |

## Verification
Three data patterns are swept across every start offset, with the length cycling through 1, 2 and 4, and all 256 bytes are read back after each sweep. The all-ones pattern exposes which bits each filter lets through, including the forced and masked bits. All-zeros shows that the forced bit 0 of the base registers survives. A position-dependent pattern catches lane-to-offset misrouting and wrap-around. Directed writes then separate a locked start from a write that merely runs into the locked range, an unchanged base rewrite from a real change, and illegal lengths from legal ones.

// File: rtl/cfg_space_pkg.sv
`timescale 1ns/1ps
package cfg_space_pkg;
  localparam int unsigned CFG_AW    = 8;
  localparam int unsigned CFG_BYTES = 1 << CFG_AW;

  localparam int unsigned PM_WIN = 64;
  localparam int unsigned SM_WIN = 16;
  localparam logic [7:0]  PM_LO_MASK = 8'(~(PM_WIN - 1));
  localparam logic [7:0]  SM_LO_MASK = 8'(~(SM_WIN - 1));

  localparam logic [7:0] OFF_CMD     = 8'h04;
  localparam logic [7:0] OFF_STAT_LO = 8'h06;
  localparam logic [7:0] OFF_INT_PIN = 8'h3D;
  localparam logic [7:0] OFF_PM_BASE = 8'h40;
  localparam logic [7:0] OFF_SM_BASE = 8'h90;
  localparam logic [7:0] LOCK_FIRST  = 8'h10;
  localparam logic [7:0] LOCK_LAST   = 8'h33;

  typedef logic [7:0] cfg_byte_t;

  function automatic logic start_locked(input logic [7:0] a);
    return (a >= LOCK_FIRST) && (a <= LOCK_LAST);
  endfunction

  function automatic logic is_fixed(input logic [7:0] off);
    case (off)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0E,
      OFF_STAT_LO, OFF_INT_PIN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic cfg_byte_t merge_byte(input logic [7:0] off,
                                           input cfg_byte_t old_b,
                                           input cfg_byte_t new_b);
    if (is_fixed(off))          return old_b;
    else if (off == OFF_CMD)    return {old_b[7:1], new_b[0]};
    else if (off == OFF_PM_BASE) return (new_b & PM_LO_MASK) | 8'h01;
    else if (off == OFF_SM_BASE) return (new_b & SM_LO_MASK) | 8'h01;
    else                         return new_b;
  endfunction
endpackage

// File: rtl/cfg_lane_filter.sv
`timescale 1ns/1ps
module cfg_lane_filter
  import cfg_space_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 3,
  localparam int unsigned DW   = 8 * LANES
)(
  input  logic                         wr_en,
  input  logic [CFG_AW-1:0]            wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [LEN_W-1:0]             wr_len,
  input  logic [LANES-1:0][7:0]        old_bytes,
  output logic [LANES-1:0]             lane_en,
  output logic [LANES-1:0][CFG_AW-1:0] lane_off,
  output logic [LANES-1:0][7:0]        lane_byte
);
  logic len_ok;
  logic start_ok;

  always_comb begin
    len_ok   = (wr_len != '0) && (32'(wr_len) <= LANES) &&
               ((wr_len & (wr_len - LEN_W'(1))) == '0);
    start_ok = !start_locked(wr_addr);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lane_off[l]  = wr_addr + CFG_AW'(l);
      lane_en[l]   = wr_en && len_ok && start_ok && (LEN_W'(l) < wr_len);
      lane_byte[l] = merge_byte(lane_off[l], old_bytes[l], wr_data[8*l +: 8]);
    end
  end
endmodule

// File: rtl/cfg_byte_file.sv
`timescale 1ns/1ps
module cfg_byte_file
  import cfg_space_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h0A17,
  parameter logic [7:0]  REV_ID    = 8'h03,
  parameter logic [23:0] CLASS_ID  = 24'h068000,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  INT_PIN   = 8'h01,
  localparam int unsigned DW       = 8 * LANES
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES-1:0]             lane_en,
  input  logic [LANES-1:0][CFG_AW-1:0] lane_off,
  input  logic [LANES-1:0][7:0]        lane_byte,
  output logic [LANES-1:0][7:0]        old_bytes,
  input  logic [CFG_AW-1:0]            rd_addr,
  output logic [DW-1:0]                rd_data,
  output logic [15:0]                  pm_bytes,
  output logic [15:0]                  sm_bytes
);
  localparam int unsigned SEL_W = $clog2(LANES);

  cfg_byte_t mem [CFG_BYTES];

  function automatic cfg_byte_t reset_byte(input int unsigned j);
    case (j)
      0:  return VENDOR_ID[7:0];
      1:  return VENDOR_ID[15:8];
      2:  return DEVICE_ID[7:0];
      3:  return DEVICE_ID[15:8];
      6:  return 8'h80;
      7:  return 8'h02;
      8:  return REV_ID;
      9:  return CLASS_ID[7:0];
      10: return CLASS_ID[15:8];
      11: return CLASS_ID[23:16];
      14: return HDR_TYPE;
      8'h3D: return INT_PIN;
      8'h40: return 8'h01;
      8'h5F: return 8'h90;
      8'h63: return 8'h60;
      8'h67: return 8'h98;
      8'h90: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int unsigned j = 0; j < CFG_BYTES; j++) mem[j] <= reset_byte(j);
    end else begin
      for (int unsigned l = 0; l < LANES; l++)
        if (lane_en[l]) mem[lane_off[l]] <= lane_byte[l];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_port
    assign old_bytes[l] = mem[lane_off[l]];
    always_ff @(posedge clk) begin
      if (rst) rd_data[8*l +: 8] <= '0;
      else     rd_data[8*l +: 8] <= mem[{rd_addr[CFG_AW-1:SEL_W], SEL_W'(l)}];
    end
  end

  assign pm_bytes = {mem[OFF_PM_BASE + 8'd1], mem[OFF_PM_BASE]};
  assign sm_bytes = {mem[OFF_SM_BASE + 8'd1], mem[OFF_SM_BASE]};

  assert_cmd_bits_R5: assert property (@(posedge clk) disable iff (rst)
    mem[OFF_CMD][7:1] == 7'd0);
  assert_status_ro_R5: assert property (@(posedge clk) disable iff (rst)
    mem[OFF_STAT_LO] == 8'h80);
  assert_int_pin_R2: assert property (@(posedge clk) disable iff (rst)
    mem[OFF_INT_PIN] == INT_PIN);
endmodule

// File: rtl/cfg_base_watch.sv
`timescale 1ns/1ps
module cfg_base_watch
  import cfg_space_pkg::*;
#(
  parameter int unsigned LANES    = 4,
  parameter int unsigned BAR_BYTES = 4
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LANES-1:0]             lane_en,
  input  logic [LANES-1:0][CFG_AW-1:0] lane_off,
  input  logic [LANES-1:0][7:0]        lane_byte,
  input  logic [LANES-1:0][7:0]        old_bytes,
  output logic                         pm_changed,
  output logic                         sm_changed
);
  logic [LANES-1:0] pm_hit;
  logic [LANES-1:0] sm_hit;

  for (genvar l = 0; l < LANES; l++) begin : g_cmp
    logic [CFG_AW-1:0] pm_rel;
    logic [CFG_AW-1:0] sm_rel;
    logic              differs;
    always_comb begin
      pm_rel    = lane_off[l] - OFF_PM_BASE;
      sm_rel    = lane_off[l] - OFF_SM_BASE;
      differs   = lane_en[l] && (lane_byte[l] != old_bytes[l]);
      pm_hit[l] = differs && (32'(pm_rel) < BAR_BYTES);
      sm_hit[l] = differs && (32'(sm_rel) < BAR_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_changed <= 1'b0;
      sm_changed <= 1'b0;
    end else begin
      pm_changed <= |pm_hit;
      sm_changed <= |sm_hit;
    end
  end
endmodule

// File: rtl/cfg_space_io.sv
`timescale 1ns/1ps
module cfg_space_io
  import cfg_space_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter logic [15:0] VENDOR_ID = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID = 16'h0A17,
  parameter logic [7:0]  REV_ID    = 8'h03,
  parameter logic [23:0] CLASS_ID  = 24'h068000,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  localparam int unsigned DW       = 8 * LANES,
  localparam int unsigned LEN_W    = $clog2(LANES) + 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [7:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [15:0]       pm_base,
  output logic [15:0]       sm_base,
  output logic              pm_changed,
  output logic              sm_changed
);
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][CFG_AW-1:0] lane_off;
  logic [LANES-1:0][7:0]        lane_byte;
  logic [LANES-1:0][7:0]        old_bytes;
  logic [15:0]                  pm_bytes;
  logic [15:0]                  sm_bytes;

  cfg_lane_filter #(.LANES(LANES), .LEN_W(LEN_W)) u_filter (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_len(wr_len),
    .old_bytes(old_bytes), .lane_en(lane_en), .lane_off(lane_off),
    .lane_byte(lane_byte)
  );

  cfg_byte_file #(
    .LANES(LANES), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REV_ID(REV_ID), .CLASS_ID(CLASS_ID), .HDR_TYPE(HDR_TYPE), .INT_PIN(8'h01)
  ) u_file (
    .clk(clk), .rst(rst), .lane_en(lane_en), .lane_off(lane_off),
    .lane_byte(lane_byte), .old_bytes(old_bytes), .rd_addr(rd_addr),
    .rd_data(rd_data), .pm_bytes(pm_bytes), .sm_bytes(sm_bytes)
  );

  cfg_base_watch #(.LANES(LANES), .BAR_BYTES(4)) u_watch (
    .clk(clk), .rst(rst), .lane_en(lane_en), .lane_off(lane_off),
    .lane_byte(lane_byte), .old_bytes(old_bytes),
    .pm_changed(pm_changed), .sm_changed(sm_changed)
  );

  assign pm_base = {pm_bytes[15:1], 1'b0};
  assign sm_base = {sm_bytes[15:1], 1'b0};

  assert_locked_start_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && start_locked(wr_addr)) |=> (!pm_changed && !sm_changed));
  assert_pm_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(pm_base) |-> pm_changed);
  assert_sm_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sm_base) |-> sm_changed);
  assert_pm_align_R7: assert property (@(posedge clk) disable iff (rst)
    pm_base[5:0] == 6'd0);
  assert_sm_align_R8: assert property (@(posedge clk) disable iff (rst)
    sm_base[3:0] == 4'd0);
endmodule

// File: tb/cfg_space_io_test.sv
`timescale 1ns/1ps
module cfg_space_io_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  wr_len = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] pm_base, sm_base;
  logic        pm_changed, sm_changed;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] model [256];

  cfg_space_io uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_len(wr_len), .rd_addr(rd_addr), .rd_data(rd_data), .pm_base(pm_base),
    .sm_base(sm_base), .pm_changed(pm_changed), .sm_changed(sm_changed)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string region(input int o);
    if (o inside {0,1,2,3,8,9,10,11,14,8'h3D}) return "R2 fixed byte";
    if (o == 4 || o == 6) return "R5 command/status";
    if (o == 8'h3C) return "R6 interrupt line";
    if (o == 8'h40) return "R7 pm base low";
    if (o == 8'h90) return "R8 sm base low";
    return "R3 plain byte";
  endfunction

  task automatic model_reset();
    for (int j = 0; j < 256; j++) model[j] = 8'h00;
    model[0] = 8'hDE; model[1] = 8'hC0; model[2] = 8'h17; model[3] = 8'h0A;
    model[6] = 8'h80; model[7] = 8'h02; model[8] = 8'h03;
    model[9] = 8'h00; model[10] = 8'h80; model[11] = 8'h06; model[14] = 8'h00;
    model[8'h3D] = 8'h01; model[8'h40] = 8'h01; model[8'h90] = 8'h01;
    model[8'h5F] = 8'h90; model[8'h63] = 8'h60; model[8'h67] = 8'h98;
  endtask

  // returns {pm_expected_strobe, sm_expected_strobe}
  function automatic logic [1:0] model_write(input int a, input logic [31:0] d, input int n);
    logic pmc = 0, smc = 0;
    if (!(n == 1 || n == 2 || n == 4)) return 2'b00;
    if (a >= 8'h10 && a <= 8'h33) return 2'b00;
    for (int k = 0; k < n; k++) begin
      int o = (a + k) % 256;
      logic [7:0] b = d[8*k +: 8];
      logic [7:0] nb;
      if (o inside {0,1,2,3,6,8,9,10,11,14,8'h3D}) nb = model[o];
      else if (o == 4) nb = {model[o][7:1], b[0]};
      else if (o == 8'h40) nb = (b & 8'hC0) | 8'h01;
      else if (o == 8'h90) nb = (b & 8'hF0) | 8'h01;
      else nb = b;
      if (nb != model[o] && o >= 8'h40 && o <= 8'h43) pmc = 1;
      if (nb != model[o] && o >= 8'h90 && o <= 8'h93) smc = 1;
      model[o] = nb;
    end
    return {pmc, smc};
  endfunction

  task automatic do_write(input int a, input logic [31:0] d, input int n);
    logic [1:0] es;
    @(negedge clk);
    wr_en = 1; wr_addr = 8'(a); wr_data = d; wr_len = 3'(n);
    es = model_write(a, d, n);
    @(posedge clk); #1;
    chk("R10 pm strobe", {31'd0, pm_changed}, {31'd0, es[1]});
    chk("R10 sm strobe", {31'd0, sm_changed}, {31'd0, es[0]});
    chk("R9 pm base", {16'd0, pm_base}, {16'd0, model[8'h41], model[8'h40] & 8'hFE});
    chk("R9 sm base", {16'd0, sm_base}, {16'd0, model[8'h91], model[8'h90] & 8'hFE});
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = 8'(a);
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic verify_all(input string phase);
    logic [31:0] v;
    for (int w = 0; w < 64; w++) begin
      do_read(w * 4, v);
      for (int k = 0; k < 4; k++)
        chk($sformatf("%s %s @%02h", phase, region(w*4+k), w*4+k),
            {24'd0, v[8*k +: 8]}, {24'd0, model[w*4+k]});
    end
  endtask

  initial begin
    logic [31:0] v;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1 reset pm strobe", {31'd0, pm_changed}, 32'd0);
    chk("R1 reset pm base", {16'd0, pm_base}, 32'd0);
    verify_all("R1 reset");

    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 256; s++) begin
        logic [31:0] d;
        int n;
        n = (s % 3 == 0) ? 1 : (s % 3 == 1) ? 2 : 4;
        d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
            (32'(s) * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
        do_write(s, d, n);
      end
      verify_all($sformatf("R3 sweep%0d", p));
    end

    // R4: locked start versus run-in from below
    do_write(8'h10, 32'h1122_3344, 4);
    do_write(8'h33, 32'h55, 1);
    do_write(8'h0E, 32'hA1B2_C3D4, 4);
    do_read(8'h10, v);
    chk("R4 run-in bytes 0x10/0x11", v & 32'h0000_FFFF, {16'd0, model[8'h11], model[8'h10]});
    chk("R4 run-in value", v & 32'h0000_FFFF, 32'h0000_A1B2);
    do_read(8'h0C, v);
    chk("R2 header type kept", {24'd0, v[23:16]}, 32'h0);

    // R3: illegal lengths ignored
    do_write(8'h70, 32'hDEAD_BEEF, 3);
    do_write(8'h70, 32'hDEAD_BEEF, 0);
    do_read(8'h72, v);
    chk("R3 illegal length ignored", v, {model[8'h73], model[8'h72], model[8'h71], model[8'h70]});

    // R5/R6 directed
    do_write(8'h04, 32'h0000_00FF, 1);
    do_read(8'h04, v);
    chk("R5 command only bit0", {24'd0, v[7:0]}, 32'h01);
    do_write(8'h3C, 32'h0B, 1);
    do_read(8'h3C, v);
    chk("R6 interrupt line", {24'd0, v[7:0]}, 32'h0B);

    // R10: equal rewrite then real change of upper base byte
    do_write(8'h40, 32'h0000_C081, 2);
    do_write(8'h40, 32'h0000_C081, 2);
    do_write(8'h43, 32'h7E, 1);
    do_write(8'h92, 32'h0000_1234, 2);
    chk("R9 pm base value", {16'd0, pm_base}, 32'h0000_C080);

    // R11: low address bits ignored
    do_read(8'h43, v);
    chk("R11 dword align", v, {model[8'h43], model[8'h42], model[8'h41], model[8'h40]});
    verify_all("R3 final");

    finish_run();
  end
endmodule